// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Polarity

This block is a small logic array whose function is set at run time. Three logic inputs feed four product terms. Two outputs each form an OR of any chosen subset of those terms. Because the OR selection is free, one product term can serve both outputs. After the OR, each output passes through an XOR stage whose polarity bit picks either the sum or its complement. This lets an output be built from whichever of its two forms shares more terms with the other output.

The connections sit in a register file that is written and read back through a simple configuration port. There is one word for each product term (its literal codes), one word for each output (its term selection mask), and one word for the polarity bits. The outputs are a purely combinational function of the inputs and the stored configuration. Reset clears every connection.

Top module: `pla_sop_array`

## Requirements
- R1: While reset is held and after it is released, every configuration word reads back as zero and both outputs are 0 for all input values.
- R2: A configuration write is visible on readback and on the outputs from the first rising clock edge on which the write enable is sampled high, and not before. Readback returns the written data masked to the field width: 6 bits for a term word, 4 bits for a mask word and 2 bits for the polarity word.
- R3: In a term word, input i (A=0, B=1, C=2) uses bits [2i+1:2i]. Code 01 includes the true literal and code 10 includes the complemented literal.
- R4: Codes 00 and 11 leave an input out of its term. A term whose three inputs are all left out evaluates to 1.
- R5: Mask word bit t set means term t is ORed into that output. An output with an empty mask has a sum of 0.
- R6: Polarity bit o set to 1 inverts output o. Bit o set to 0 passes the sum unchanged.
- R7: A single product term may be selected by both outputs at the same time, and it contributes to each of them.
- R8: The address map is: term t at address t (0 to 3), the mask for output o at address 4+o, and the polarity word at address 6. A write to address 7 changes nothing, and reading address 7 returns 0.
- R9: With terms AB', AC, BC and A'BC', output 0 selecting terms 0, 1 and 3 in true polarity, and output 1 selecting terms 1 and 2 in complement polarity, the outputs equal AB'+AC+A'BC' and (AC+BC)' for all 8 input combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset; clears all configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration word address, used for both write and readback |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_rdata | output | 6 | Combinational readback of the addressed word |
| x_in | input | 3 | Logic inputs: bit 0 = A, bit 1 = B, bit 2 = C |
| f_out | output | 2 | Array outputs after the polarity stage |

## Verification
The hardest condition to reach from the ports is a product term that drives both outputs while the two outputs have opposite polarity. In that case one term flip moves the outputs in opposite directions, and a fault in the term sharing or in the XOR stage shows up in only some input rows. The stimulus reaches it by writing the full reference configuration and then sweeping all eight input values. It also reaches it with configurations built from the reserved code 11 and from all-open terms, which makes a term constant 1 on one output while the other output still depends on literals. Ignored writes to the unused address are checked by reading back every word and sweeping the outputs again.

// File: rtl/pla_sop_array.sv
module pla_sop_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 4,
  parameter int N_OUT  = 2,
  localparam int TW    = 2 * N_IN,
  localparam int DW    = (TW > N_TERM) ? ((TW > N_OUT) ? TW : N_OUT)
                                       : ((N_TERM > N_OUT) ? N_TERM : N_OUT),
  localparam int N_REG = N_TERM + N_OUT + 1,
  localparam int AW    = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic [N_IN-1:0]  x_in,
  output logic [N_OUT-1:0] f_out
);
  localparam int MASK_BASE = N_TERM;
  localparam int POL_ADDR  = N_TERM + N_OUT;

  logic [N_TERM-1:0][TW-1:0]     and_cfg;
  logic [N_OUT-1:0][N_TERM-1:0]  or_cfg;
  logic [N_OUT-1:0]              pol_cfg;
  logic [N_TERM-1:0][N_IN-1:0]   lit;
  logic [N_TERM-1:0]             term;
  logic [N_OUT-1:0]              sum;
  logic                          addr_ok;

  assign addr_ok = int'(cfg_addr) < N_REG;

  genvar t, i, o;
  generate
    for (t = 0; t < N_TERM; t++) begin : g_term
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) and_cfg[t] <= '0;
        else if (cfg_we && int'(cfg_addr) == t) and_cfg[t] <= cfg_wdata[TW-1:0];

      for (i = 0; i < N_IN; i++) begin : g_lit
        assign lit[t][i] = (and_cfg[t][2*i +: 2] == 2'b01) ?  x_in[i] :
                           (and_cfg[t][2*i +: 2] == 2'b10) ? ~x_in[i] : 1'b1;
      end
      assign term[t] = &lit[t];
    end

    for (o = 0; o < N_OUT; o++) begin : g_out
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) or_cfg[o] <= '0;
        else if (cfg_we && int'(cfg_addr) == MASK_BASE + o) or_cfg[o] <= cfg_wdata[N_TERM-1:0];

      assign sum[o]   = |(term & or_cfg[o]);
      assign f_out[o] = sum[o] ^ pol_cfg[o];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pol_cfg <= '0;
    else if (cfg_we && int'(cfg_addr) == POL_ADDR) pol_cfg <= cfg_wdata[N_OUT-1:0];

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < N_TERM; k++)
      if (int'(cfg_addr) == k) cfg_rdata = DW'(and_cfg[k]);
    for (int k = 0; k < N_OUT; k++)
      if (int'(cfg_addr) == MASK_BASE + k) cfg_rdata = DW'(or_cfg[k]);
    if (int'(cfg_addr) == POL_ADDR) cfg_rdata = DW'(pol_cfg);
  end

  function automatic logic [DW-1:0] field_mask(input logic [AW-1:0] a);
    int w;
    logic [DW-1:0] m;
    w = (int'(a) < MASK_BASE) ? TW : (int'(a) < POL_ADDR) ? N_TERM : N_OUT;
    m = '0;
    for (int b = 0; b < DW; b++) if (b < w) m[b] = 1'b1;
    return m;
  endfunction

  logic [N_TERM-1:0] open_term;
  always_comb
    for (int k = 0; k < N_TERM; k++) begin
      open_term[k] = 1'b1;
      for (int j = 0; j < N_IN; j++)
        if (^and_cfg[k][2*j +: 2]) open_term[k] = 1'b0;
    end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && addr_ok) |=> (cfg_addr != $past(cfg_addr)) ||
                            (cfg_rdata == ($past(cfg_wdata) & field_mask($past(cfg_addr)))));

  assert_readback_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (cfg_addr != $past(cfg_addr)) || $stable(cfg_rdata));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok |-> cfg_rdata == '0);

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !addr_ok) |=> $stable(pol_cfg) && $stable(or_cfg) && $stable(and_cfg));

  generate
    for (o = 0; o < N_OUT; o++) begin : g_chk
      assert_empty_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (or_cfg[o] == '0) |-> f_out[o] == pol_cfg[o]);

      assert_open_term_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((or_cfg[o] & open_term) != '0) |-> f_out[o] == ~pol_cfg[o]);
    end
  endgenerate
endmodule

// File: tb/pla_sop_array_bench.sv
module pla_sop_array_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic [2:0] x_in = '0;
  logic [1:0] f_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0] m_and [4];
  logic [3:0] m_or  [2];
  logic [1:0] m_pol;

  pla_sop_array u_pla_sop_array (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .x_in(x_in), .f_out(f_out));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [2:0] x);
    logic [3:0] tv;
    logic [1:0] r;
    for (int t = 0; t < 4; t++) begin
      tv[t] = 1'b1;
      for (int i = 0; i < 3; i++) begin
        if (m_and[t][2*i +: 2] == 2'b01 && !x[i]) tv[t] = 1'b0;
        if (m_and[t][2*i +: 2] == 2'b10 &&  x[i]) tv[t] = 1'b0;
      end
    end
    for (int o = 0; o < 2; o++) r[o] = (|(tv & m_or[o])) ^ m_pol[o];
    return r;
  endfunction

  function automatic logic [5:0] fmask(input int a);
    return (a < 4) ? 6'h3F : (a < 6) ? 6'h0F : (a == 6) ? 6'h03 : 6'h00;
  endfunction

  task automatic model_clear();
    for (int t = 0; t < 4; t++) m_and[t] = '0;
    m_or[0] = '0; m_or[1] = '0; m_pol = '0;
  endtask

  task automatic wr(input int a, input logic [5:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 4) m_and[a] = d;
    else if (a < 6) m_or[a-4] = d[3:0];
    else if (a == 6) m_pol = d[1:0];
  endtask

  task automatic sweep(input string req);
    @(negedge clk);
    for (int x = 0; x < 8; x++) begin
      x_in = 3'(x);
      #1;
      check(req, {4'b0, f_out}, {4'b0, model(3'(x))});
    end
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      cfg_addr = 3'(a);
      #1;
      if (a < 4) check(req, cfg_rdata, m_and[a] & fmask(a));
      else if (a < 6) check(req, cfg_rdata, {2'b0, m_or[a-4]});
      else if (a == 6) check(req, cfg_rdata, {4'b0, m_pol});
      else check(req, cfg_rdata, 6'h00);
    end
  endtask

  task automatic t_reset();
    model_clear();
    read_all("R1 readback after reset");
    sweep("R1 outputs after reset");
  endtask

  task automatic t_write_timing();
    @(negedge clk);
    cfg_addr = 3'd6; cfg_we = 1'b1; cfg_wdata = 6'h3F;
    #1 check("R2 not visible before edge", cfg_rdata, 6'h00);
    @(negedge clk);
    cfg_we = 1'b0;
    check("R2 polarity masked to 2 bits", cfg_rdata, 6'h03);
    m_pol = 2'b11;
    sweep("R2 R6 inverted empty sums");
    wr(4, 6'h3F);
    wr(0, 6'h3F);
    read_all("R2 masked readback");
  endtask

  task automatic t_literals();
    model_clear();
    for (int a = 0; a < 7; a++) wr(a, 6'h00);
    wr(0, 6'h01);
    wr(1, 6'h28);
    wr(4, 6'h01);
    wr(5, 6'h02);
    sweep("R3 true literal A and complement literals");
    wr(0, 6'h16);
    wr(1, 6'h3C);
    sweep("R3 R4 mixed and reserved codes");
    wr(4, 6'h00);
    sweep("R5 empty mask gives 0");
  endtask

  task automatic t_open_and_share();
    wr(0, 6'h00);
    wr(1, 6'h21);
    wr(4, 6'h03);
    wr(5, 6'h02);
    wr(6, 6'h02);
    sweep("R4 all-open term is 1, R7 shared term");
    wr(0, 6'h3F);
    wr(6, 6'h01);
    sweep("R4 all-reserved term is 1, R6 polarity");
    wr(0, 6'h24);
    wr(4, 6'h05);
    wr(5, 6'h05);
    sweep("R7 two terms shared by both outputs");
  endtask

  task automatic t_reference();
    wr(0, 6'h09); wr(1, 6'h11); wr(2, 6'h14); wr(3, 6'h26);
    wr(4, 6'h0B); wr(5, 6'h06); wr(6, 6'h02);
    @(negedge clk);
    for (int x = 0; x < 8; x++) begin
      logic a, b, c, e1, e2;
      x_in = 3'(x);
      a = x_in[0]; b = x_in[1]; c = x_in[2];
      e1 = (a & ~b) | (a & c) | (~a & b & ~c);
      e2 = ~((a & c) | (b & c));
      #1;
      check("R9 reference output 0", {5'b0, f_out[0]}, {5'b0, e1});
      check("R9 reference output 1", {5'b0, f_out[1]}, {5'b0, e2});
    end
  endtask

  task automatic t_unmapped();
    wr(7, 6'h3F);
    read_all("R8 unmapped write ignored");
    sweep("R8 outputs unchanged after unmapped write");
  endtask

  task automatic t_reset_again();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    sweep("R1 outputs during reset");
    @(negedge clk);
    rst_n = 1'b1;
    read_all("R1 readback after second reset");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_timing();
    t_literals();
    t_open_and_share();
    t_reference();
    t_unmapped();
    t_reset_again();
    finish_run();
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end
endmodule